// File: doc/BRIEF.md
# Bit-Enabled Control Register Bank for a PCIe Root-Port Wrapper

This block is the small register slave that sits beside a PCIe controller core in a chip's glue logic. Software reaches it over a 32-bit APB-style bus with zero wait states. It holds three writable control words: a general control word, a legacy interrupt mask and a hot-reset control word. It also shows two read-only views of live inputs: the four legacy interrupt lines and the link-training status.

Each writable word uses a bit-enabled write. The upper halfword of the write data picks which bits of the lower halfword are updated. Software can therefore set or clear one control bit without first reading the register. The bank also decodes a few control bits into dedicated outputs. It merges the four legacy interrupt lines with their mask bits into one level-sensitive interrupt request.

Top module: `pcie_glue_regbank`

## Requirements
- R1: After reset, the control word, the interrupt mask and the hot-reset word are all 0. With no interrupt line active, rc_mode_o, train_start_o, enhanced_ctl_o and irq_o are all 0.
- R2: A write to a bit-enabled register updates lower bit n from pwdata[n] only when pwdata[n+16] is 1. Every lower bit whose enable is 0 keeps its value.
- R3: The control word is at offset 0x000 and is visible on ctl_word_o. rc_mode_o equals its bit 6. train_start_o is 1 exactly when its bits 3 and 2 are both 1.
- R4: Offset 0x008 reads the live interrupt lines, with line n (INTA=0 … INTD=3) in bit n and all other bits 0. Writes to this offset change nothing.
- R5: The interrupt mask is at offset 0x01C and uses bits 3:0 with bit-enabled writes. A read returns the mask in bits 3:0 and 0 in all other bits.
- R6: irq_o is the OR over n of (line n AND NOT mask bit n). It follows the lines in the same cycle and holds no latched state.
- R7: The hot-reset word is at offset 0x180 and reads back all 16 stored bits. enhanced_ctl_o equals its bit 4.
- R8: Offset 0x300 reads the training state in bits 5:0, the physical-layer link-up in bit 16 and the data-link link-up in bit 17. All other bits read 0, and writes change nothing.
- R9: A read from any other word offset returns 0. A write to it changes no register and raises no error.
- R10: A write takes effect only in the access phase (psel, penable and pwrite all 1). A setup phase alone changes nothing. While psel is 1, prdata shows the addressed word. While psel is 0, prdata is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase strobe |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 12 | Byte address; bits 1:0 ignored |
| pwdata | input | 32 | Write data; bits 31:16 are the per-bit enables |
| prdata | output | 32 | Read data |
| intx_i | input | 4 | Legacy interrupt lines, INTA in bit 0 |
| ltssm_state_i | input | 6 | Current link-training state |
| phy_link_up_i | input | 1 | Physical-layer link-up indication |
| dl_link_up_i | input | 1 | Data-link-layer link-up indication |
| ctl_word_o | output | 16 | Stored general control word |
| rc_mode_o | output | 1 | Root-complex mode select |
| train_start_o | output | 1 | Link-training start request |
| enhanced_ctl_o | output | 1 | Enhanced training-enable control mode |
| irq_o | output | 1 | Combined level-sensitive legacy interrupt |

## Verification
The bench builds the bank with its defaults: 12 address bits, four interrupt lines and a 6-bit training state. These values let random traffic reach every mapped offset and a wide range of unmapped word offsets. With four lines and four mask bits, every mask and line combination that feeds irq_o is reachable in a few hundred operations. Random enable halves exercise partial updates where enabled and disabled bits sit next to each other.

// File: rtl/pcie_glue_pkg.sv
package pcie_glue_pkg;

   // Register selected by the current bus address
   typedef enum logic [2:0] {
      SEL_NONE  = 3'd0,
      SEL_CTRL  = 3'd1,
      SEL_ISTAT = 3'd2,
      SEL_IMASK = 3'd3,
      SEL_HRST  = 3'd4,
      SEL_LINK  = 3'd5
   } reg_sel_e;

   localparam int unsigned HALF_W = 16;

   // Merge a bit-enabled write into an old value
   function automatic logic [HALF_W-1:0] bit_merge(
      input logic [HALF_W-1:0] old_v,
      input logic [HALF_W-1:0] new_v,
      input logic [HALF_W-1:0] en_v);
      return (old_v & ~en_v) | (new_v & en_v);
   endfunction

endpackage

// File: rtl/pcie_glue_decode.sv
module pcie_glue_decode
   import pcie_glue_pkg::*;
#(
   parameter int unsigned ADDR_W   = 12,
   parameter int unsigned OFF_CTRL  = 'h000,
   parameter int unsigned OFF_ISTAT = 'h008,
   parameter int unsigned OFF_IMASK = 'h01C,
   parameter int unsigned OFF_HRST  = 'h180,
   parameter int unsigned OFF_LINK  = 'h300
) (
   input  logic [ADDR_W-1:0] addr_i,
   output reg_sel_e          sel_o
);
   localparam int unsigned WA_W = ADDR_W - 2;

   localparam logic [WA_W-1:0] WA_CTRL  = WA_W'(OFF_CTRL  >> 2);
   localparam logic [WA_W-1:0] WA_ISTAT = WA_W'(OFF_ISTAT >> 2);
   localparam logic [WA_W-1:0] WA_IMASK = WA_W'(OFF_IMASK >> 2);
   localparam logic [WA_W-1:0] WA_HRST  = WA_W'(OFF_HRST  >> 2);
   localparam logic [WA_W-1:0] WA_LINK  = WA_W'(OFF_LINK  >> 2);

   logic [WA_W-1:0] waddr;
   logic [1:0]      unused_byte_lane;

   assign waddr            = addr_i[ADDR_W-1:2];
   assign unused_byte_lane = addr_i[1:0];

   always_comb begin
      sel_o = SEL_NONE;
      if      (waddr == WA_CTRL)  sel_o = SEL_CTRL;
      else if (waddr == WA_ISTAT) sel_o = SEL_ISTAT;
      else if (waddr == WA_IMASK) sel_o = SEL_IMASK;
      else if (waddr == WA_HRST)  sel_o = SEL_HRST;
      else if (waddr == WA_LINK)  sel_o = SEL_LINK;
   end

endmodule

// File: rtl/pcie_glue_bitreg.sv
module pcie_glue_bitreg #(
   parameter int unsigned       WIDTH     = 16,
   parameter logic [WIDTH-1:0]  RESET_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_i,
   input  logic [WIDTH-1:0] val_i,
   input  logic [WIDTH-1:0] en_i,
   output logic [WIDTH-1:0] q_o
);
   if (WIDTH < 1 || WIDTH > 16) begin : g_bad_width
      $error("pcie_glue_bitreg: WIDTH must be 1..16");
   end

   // One flop per bit; each bit has its own write enable
   for (genvar b = 0; b < WIDTH; b++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            q_o[b] <= RESET_VAL[b];
         else if (wr_i && en_i[b])
            q_o[b] <= val_i[b];
      end
   end

endmodule

// File: rtl/pcie_glue_intx.sv
module pcie_glue_intx #(
   parameter int unsigned N_LINES = 4
) (
   input  logic [N_LINES-1:0] line_i,
   input  logic [N_LINES-1:0] mask_i,
   output logic               irq_o
);
   logic [N_LINES-1:0] pass;

   for (genvar n = 0; n < N_LINES; n++) begin : g_gate
      assign pass[n] = line_i[n] & ~mask_i[n];
   end

   assign irq_o = |pass;

endmodule

// File: rtl/pcie_glue_regbank.sv
module pcie_glue_regbank
   import pcie_glue_pkg::*;
#(
   parameter int unsigned ADDR_W     = 12,
   parameter int unsigned DATA_W     = 32,
   parameter int unsigned N_INTX     = 4,
   parameter int unsigned STATE_W    = 6,
   parameter int unsigned RC_BIT     = 6,
   parameter int unsigned TRAIN_LSB  = 2,
   parameter int unsigned ENH_BIT    = 4,
   parameter int unsigned LINKUP_LSB = 16,
   parameter int unsigned OFF_CTRL   = 'h000,
   parameter int unsigned OFF_ISTAT  = 'h008,
   parameter int unsigned OFF_IMASK  = 'h01C,
   parameter int unsigned OFF_HRST   = 'h180,
   parameter int unsigned OFF_LINK   = 'h300
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              psel,
   input  logic              penable,
   input  logic              pwrite,
   input  logic [ADDR_W-1:0] paddr,
   input  logic [DATA_W-1:0] pwdata,
   output logic [DATA_W-1:0] prdata,
   input  logic [N_INTX-1:0] intx_i,
   input  logic [STATE_W-1:0] ltssm_state_i,
   input  logic              phy_link_up_i,
   input  logic              dl_link_up_i,
   output logic [HALF_W-1:0] ctl_word_o,
   output logic              rc_mode_o,
   output logic              train_start_o,
   output logic              enhanced_ctl_o,
   output logic              irq_o
);
   // Elaboration-time parameter checks
   if (DATA_W != 2 * HALF_W) begin : g_bad_data
      $error("pcie_glue_regbank: DATA_W must be 32");
   end
   if (N_INTX < 1 || N_INTX > HALF_W) begin : g_bad_intx
      $error("pcie_glue_regbank: N_INTX must be 1..16");
   end
   if (STATE_W > LINKUP_LSB || LINKUP_LSB + 2 > DATA_W) begin : g_bad_link
      $error("pcie_glue_regbank: link status fields overlap or overflow");
   end
   if (RC_BIT >= HALF_W || TRAIN_LSB + 1 >= HALF_W || ENH_BIT >= HALF_W) begin : g_bad_bits
      $error("pcie_glue_regbank: control bit index out of range");
   end
   if (ADDR_W < 3) begin : g_bad_addr
      $error("pcie_glue_regbank: ADDR_W too small");
   end

   reg_sel_e          sel;
   logic              wr_acc;
   logic [HALF_W-1:0] wval;
   logic [HALF_W-1:0] wen;
   logic [HALF_W-1:0] hrst_q;
   logic [N_INTX-1:0] imask_q;

   assign wr_acc = psel & penable & pwrite;
   assign wval   = pwdata[HALF_W-1:0];
   assign wen    = pwdata[DATA_W-1:HALF_W];

   pcie_glue_decode #(
      .ADDR_W   (ADDR_W),
      .OFF_CTRL (OFF_CTRL),
      .OFF_ISTAT(OFF_ISTAT),
      .OFF_IMASK(OFF_IMASK),
      .OFF_HRST (OFF_HRST),
      .OFF_LINK (OFF_LINK)
   ) u_decode (
      .addr_i(paddr),
      .sel_o (sel)
   );

   pcie_glue_bitreg #(.WIDTH(HALF_W)) u_ctrl (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (wr_acc && sel == SEL_CTRL),
      .val_i(wval),
      .en_i (wen),
      .q_o  (ctl_word_o)
   );

   pcie_glue_bitreg #(.WIDTH(N_INTX)) u_imask (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (wr_acc && sel == SEL_IMASK),
      .val_i(wval[N_INTX-1:0]),
      .en_i (wen[N_INTX-1:0]),
      .q_o  (imask_q)
   );

   pcie_glue_bitreg #(.WIDTH(HALF_W)) u_hrst (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_i (wr_acc && sel == SEL_HRST),
      .val_i(wval),
      .en_i (wen),
      .q_o  (hrst_q)
   );

   pcie_glue_intx #(.N_LINES(N_INTX)) u_intx (
      .line_i(intx_i),
      .mask_i(imask_q),
      .irq_o (irq_o)
   );

   // Decoded control bits
   assign rc_mode_o      = ctl_word_o[RC_BIT];
   assign train_start_o  = &ctl_word_o[TRAIN_LSB +: 2];
   assign enhanced_ctl_o = hrst_q[ENH_BIT];

   // Read data mux; all unused bits read as zero
   always_comb begin
      prdata = '0;
      if (psel) begin
         unique case (sel)
            SEL_CTRL:  prdata[HALF_W-1:0]  = ctl_word_o;
            SEL_ISTAT: prdata[N_INTX-1:0]  = intx_i;
            SEL_IMASK: prdata[N_INTX-1:0]  = imask_q;
            SEL_HRST:  prdata[HALF_W-1:0]  = hrst_q;
            SEL_LINK: begin
               prdata[STATE_W-1:0]    = ltssm_state_i;
               prdata[LINKUP_LSB]     = phy_link_up_i;
               prdata[LINKUP_LSB + 1] = dl_link_up_i;
            end
            default:   prdata = '0;
         endcase
      end
   end

endmodule

// File: rtl/pcie_glue_regbank_chk.sv
module pcie_glue_regbank_chk #(
   parameter int unsigned ADDR_W  = 12,
   parameter int unsigned N_INTX  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              psel,
   input logic              penable,
   input logic              pwrite,
   input logic [ADDR_W-1:0] paddr,
   input logic [31:0]       pwdata,
   input logic [31:0]       prdata,
   input logic [N_INTX-1:0] intx_i,
   input logic [15:0]       ctl_word_o,
   input logic              rc_mode_o,
   input logic              enhanced_ctl_o,
   input logic              irq_o
);
   logic [ADDR_W-3:0] wa;
   logic              acc, wr_ctrl, wr_hrst, rd, mapped;

   assign wa      = paddr[ADDR_W-1:2];
   assign acc     = psel && penable && pwrite;
   assign wr_ctrl = acc && wa == (ADDR_W-2)'('h000 >> 2);
   assign wr_hrst = acc && wa == (ADDR_W-2)'('h180 >> 2);
   assign rd      = psel && !pwrite;
   assign mapped  = wa == (ADDR_W-2)'('h000 >> 2) || wa == (ADDR_W-2)'('h008 >> 2) ||
                    wa == (ADDR_W-2)'('h01C >> 2) || wa == (ADDR_W-2)'('h180 >> 2) ||
                    wa == (ADDR_W-2)'('h300 >> 2);

   assert_keep_unenabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> ((ctl_word_o ^ $past(ctl_word_o)) & ~$past(pwdata[31:16])) == 16'h0);

   assert_take_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wr_ctrl |=> (ctl_word_o & $past(pwdata[31:16])) == ($past(pwdata[15:0]) & $past(pwdata[31:16])));

   assert_rc_mode_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ctrl && pwdata[22]) |=> rc_mode_o == $past(pwdata[6]));

   assert_enh_mode_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_hrst && pwdata[20]) |=> enhanced_ctl_o == $past(pwdata[4]));

   assert_irq_needs_line_R6: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> intx_i != '0);

   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd && !mapped) |-> prdata == 32'h0);

   assert_no_access_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !acc |=> $stable(ctl_word_o));

   assert_idle_bus_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !psel |-> prdata == 32'h0);

endmodule

bind pcie_glue_regbank pcie_glue_regbank_chk #(
   .ADDR_W(ADDR_W),
   .N_INTX(N_INTX)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .psel          (psel),
   .penable       (penable),
   .pwrite        (pwrite),
   .paddr         (paddr),
   .pwdata        (pwdata),
   .prdata        (prdata),
   .intx_i        (intx_i),
   .ctl_word_o    (ctl_word_o),
   .rc_mode_o     (rc_mode_o),
   .enhanced_ctl_o(enhanced_ctl_o),
   .irq_o         (irq_o)
);

// File: tb/pcie_glue_regbank_tb.sv
module pcie_glue_regbank_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
   logic [11:0] paddr = '0;
   logic [31:0] pwdata = '0;
   logic [31:0] prdata;
   logic [3:0]  intx = '0;
   logic [5:0]  st = '0;
   logic        phy_up = 1'b0, dl_up = 1'b0;
   logic [15:0] ctl_word;
   logic        rc_mode, train_start, enh, irq;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   // Reference model state
   logic [15:0] ctrl_m = '0;
   logic [3:0]  mask_m = '0;
   logic [15:0] hr_m   = '0;

   always #2 clk = ~clk;

   pcie_glue_regbank u_dut (
      .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
      .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .intx_i(intx),
      .ltssm_state_i(st), .phy_link_up_i(phy_up), .dl_link_up_i(dl_up),
      .ctl_word_o(ctl_word), .rc_mode_o(rc_mode), .train_start_o(train_start),
      .enhanced_ctl_o(enh), .irq_o(irq)
   );

   function automatic logic [15:0] mrg(input logic [15:0] o, input logic [31:0] w);
      return (o & ~w[31:16]) | (w[15:0] & w[31:16]);
   endfunction

   function automatic bit is_mapped(input logic [11:0] a);
      return a == 12'h000 || a == 12'h008 || a == 12'h01C || a == 12'h180 || a == 12'h300;
   endfunction

   function automatic logic [31:0] exp_rd(input logic [11:0] a);
      case (a)
         12'h000: return {16'h0, ctrl_m};
         12'h008: return {28'h0, intx};
         12'h01C: return {28'h0, mask_m};
         12'h180: return {16'h0, hr_m};
         12'h300: return {14'h0, dl_up, phy_up, 10'h0, st};
         default: return 32'h0;
      endcase
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %08h expected %08h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   task automatic model_write(input logic [11:0] a, input logic [31:0] d);
      logic [15:0] t;
      case (a)
         12'h000: ctrl_m = mrg(ctrl_m, d);
         12'h01C: begin t = mrg({12'h0, mask_m}, d); mask_m = t[3:0]; end
         12'h180: hr_m = mrg(hr_m, d);
         default: ;
      endcase
   endtask

   task automatic apb_wr(input logic [11:0] a, input logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
      model_write(a, d);
   endtask

   task automatic apb_rd(input logic [11:0] a, output logic [31:0] d);
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
      #1 d = prdata;
      @(negedge clk);
      penable = 1'b1;
      @(negedge clk);
      psel = 1'b0; penable = 1'b0;
   endtask

   task automatic check_outs(input string tag);
      #1;
      check({tag, " R3 ctl_word"}, {16'h0, ctl_word}, {16'h0, ctrl_m});
      check({tag, " R3 rc_mode"}, {31'h0, rc_mode}, {31'h0, ctrl_m[6]});
      check({tag, " R3 train_start"}, {31'h0, train_start}, {31'h0, ctrl_m[3] & ctrl_m[2]});
      check({tag, " R7 enhanced"}, {31'h0, enh}, {31'h0, hr_m[4]});
      check({tag, " R6 irq"}, {31'h0, irq}, {31'h0, |(intx & ~mask_m)});
   endtask

   function automatic logic [11:0] pick_addr();
      logic [11:0] a;
      case ($urandom_range(0, 5))
         0: a = 12'h000;
         1: a = 12'h008;
         2: a = 12'h01C;
         3: a = 12'h180;
         4: a = 12'h300;
         default: begin
            a = {$urandom_range(0, 1023), 2'b00};
            while (is_mapped(a)) a = a + 12'h004;
         end
      endcase
      return a;
   endfunction

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      logic [31:0] rd;
      void'($urandom(32'h5EED_2024));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      check_outs("R1 reset");
      apb_rd(12'h000, rd); check("R1 ctrl reset", rd, 32'h0);
      apb_rd(12'h01C, rd); check("R1 mask reset", rd, 32'h0);
      apb_rd(12'h180, rd); check("R1 hrst reset", rd, 32'h0);

      // R10: idle bus reads zero
      #1 check("R10 idle prdata", prdata, 32'h0);

      // R3: training start needs both bits, root-complex mode bit
      apb_wr(12'h000, 32'h0004_0004); check_outs("R3 one bit");
      check("R3 train needs both", {31'h0, train_start}, 32'h0);
      apb_wr(12'h000, 32'h0048_0048); check_outs("R3 both bits");
      check("R3 train on", {31'h0, train_start}, 32'h1);
      check("R3 rc on", {31'h0, rc_mode}, 32'h1);

      // R2: only enabled bit changes
      apb_wr(12'h000, 32'h0001_FFFF);
      apb_rd(12'h000, rd); check("R2 single enable", rd, 32'h0000_004D);
      apb_wr(12'h000, 32'h0040_0000);
      apb_rd(12'h000, rd); check("R2 clear one", rd, 32'h0000_000D);
      apb_wr(12'h000, 32'h0000_FFFF);
      apb_rd(12'h000, rd); check("R2 no enables", rd, 32'h0000_000D);

      // R10: setup phase alone writes nothing
      @(negedge clk);
      psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 12'h000; pwdata = 32'hFFFF_0000;
      @(negedge clk);
      psel = 1'b0; pwrite = 1'b0;
      apb_rd(12'h000, rd); check("R10 setup only", rd, 32'h0000_000D);

      // R7: hot reset word
      apb_wr(12'h180, 32'hFFFF_A5B0);
      apb_rd(12'h180, rd); check("R7 hrst readback", rd, 32'h0000_A5B0);
      check_outs("R7 enh");

      // R5 / R6: mask and interrupt combining
      apb_wr(12'h01C, 32'hFFFF_FFF5);
      apb_rd(12'h01C, rd); check("R5 mask readback", rd, 32'h0000_0005);
      intx = 4'b0101; check_outs("R6 all masked");
      check("R6 masked irq", {31'h0, irq}, 32'h0);
      intx = 4'b0010; check_outs("R6 unmasked line");
      check("R6 unmasked irq", {31'h0, irq}, 32'h1);
      apb_wr(12'h01C, 32'h0002_0002); intx = 4'b0010; check_outs("R6 after mask");
      check("R6 irq now masked", {31'h0, irq}, 32'h0);

      // R4: status reads live, writes ignored
      intx = 4'b1001;
      apb_wr(12'h008, 32'hFFFF_FFFF);
      apb_rd(12'h008, rd); check("R4 status live", rd, 32'h0000_0009);
      check_outs("R4 after status write");

      // R8: link status
      st = 6'h11; phy_up = 1'b1; dl_up = 1'b0;
      apb_wr(12'h300, 32'hFFFF_FFFF);
      apb_rd(12'h300, rd); check("R8 link", rd, 32'h0001_0011);
      dl_up = 1'b1; phy_up = 1'b0; st = 6'h3F;
      apb_rd(12'h300, rd); check("R8 link bits", rd, 32'h0002_003F);

      // R9: unmapped
      apb_wr(12'h004, 32'hFFFF_FFFF);
      apb_rd(12'h004, rd); check("R9 unmapped read", rd, 32'h0);
      apb_rd(12'h000, rd); check("R9 ctrl untouched", rd, {16'h0, ctrl_m});
      apb_rd(12'h01C, rd); check("R9 mask untouched", rd, {28'h0, mask_m});
      apb_rd(12'h180, rd); check("R9 hrst untouched", rd, {16'h0, hr_m});

      // Random traffic: R2 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 400; i++) begin
         logic [11:0] a;
         a = pick_addr();
         intx = 4'($urandom); st = 6'($urandom);
         phy_up = 1'($urandom); dl_up = 1'($urandom);
         if ($urandom_range(0, 1) == 1) begin
            apb_wr(a, $urandom);
            check_outs("R2 random write");
         end
         a = pick_addr();
         apb_rd(a, rd);
         check(is_mapped(a) ? "R2 random read" : "R9 random unmapped", rd, exp_rd(a));
      end

      summary();
   end

endmodule